// File: doc/BRIEF.md
# Configurable SPI Frame Master

This block is the serial engine of an SPI controller. A host drives a 32-bit frame configuration word and a transmit word, then pulses `start`. The block lowers the chip select and waits a programmable setup interval. It then clocks out one frame of 4 to 16 bits on SCK and MOSI while capturing MISO, waits a programmable hold interval, and raises the chip select again. It signals completion with a one-cycle `done` pulse, and the received word is presented right-aligned on `rx_data`.

The configuration word is captured when a frame is accepted, so the host may change it freely while a frame runs. The word sets the frame length, clock polarity and phase, and bit order. It also sets three timing values: the SCK half period, the setup interval and the hold interval. Each timing value is the product of an odd prescaler (1, 3, 5 or 7) and a power of two.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, `cs_n` is 1, `busy` is 0, `done` is 0, and `sck` is 0 while `cfg_word` is 0.
- R2: A `start` seen while idle makes `cs_n` go low in the next cycle. `cs_n` then stays low for a setup interval of S = p*2^(j+1) cycles before the shift phase begins, where p = 1, 3, 5, 7 for prescaler code bits 23:22 = 0..3 and j is the code in bits 15:12.
- R3: SCK starts at the CPOL level (bit 26) and toggles every H = p*2^j cycles, where p comes from bits 17:16 (codes 0..3 give 1, 3, 5, 7) and j from bits 3:0. The first toggle comes H cycles into the shift phase, a frame has exactly 2N toggles, and SCK ends at the CPOL level.
- R4: With bit 25 = 0, MISO is sampled on odd-numbered SCK edges and MOSI changes on even-numbered ones. With bit 25 = 1, MOSI changes on odd-numbered edges after the first, and MISO is sampled on even-numbered edges.
- R5: Bit 24 = 0 sends and receives the most significant frame bit first. Bit 24 = 1 sends and receives the least significant bit first.
- R6: Bits 30:27 hold the frame length minus one. Codes 3..15 give 4..16 bits, and codes 0..2 are treated as a 4-bit frame.
- R7: After the last SCK edge, `cs_n` stays low for a hold interval of p*2^(j+1) cycles, where p comes from bits 21:20 (codes 0..3 give 1, 3, 5, 7) and j from bits 11:8. `cs_n` then returns high.
- R8: `done` is high for exactly the one cycle in which `cs_n` first returns high. In that cycle `rx_data` holds the received bits right-aligned, with all bits above the frame length at 0.
- R9: While `busy` is high, `start`, `tx_data` and `cfg_word` have no effect on the running frame, and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Frame configuration word, captured at start |
| start | input | 1 | Request a frame (accepted only when idle) |
| tx_data | input | 16 | Transmit word, right-aligned |
| busy | output | 1 | High from frame acceptance until chip select returns high |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 16 | Received word, right-aligned |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |

## Verification
Let t = 0 be the first cycle after the edge that accepts `start`. Then `cs_n` is low from t = 0 and the setup interval covers t < S. SCK edge e becomes visible at t = S + e*H, and both `cs_n` rising and `done` fall at t = S + 2N*H + Hold. The bench recomputes these instants from the configuration fields for every frame. It compares `sck`, `cs_n`, `busy`, `done` and `mosi` once per cycle on the falling clock edge. It checks `rx_data` in the `done` cycle and confirms `done` has cleared one cycle later. It drives MISO on the falling edge from the edge count then visible, so the value is settled before the capturing rising edge.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    localparam int unsigned CNT_W   = 20;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned LEN_W   = 4;
    localparam int unsigned EDGE_W  = LEN_W + 2;

    // configuration word field positions
    localparam int unsigned F_LEN_LO   = 27;
    localparam int unsigned F_CPOL     = 26;
    localparam int unsigned F_CPHA     = 25;
    localparam int unsigned F_LSB      = 24;
    localparam int unsigned F_SPRE_LO  = 22;
    localparam int unsigned F_HPRE_LO  = 20;
    localparam int unsigned F_BPRE_LO  = 16;
    localparam int unsigned F_SSC_LO   = 12;
    localparam int unsigned F_HSC_LO   = 8;
    localparam int unsigned F_BSC_LO   = 0;

    localparam logic [LEN_W-1:0] MIN_LEN_M1 = 4'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD
    } fm_state_t;

    typedef struct packed {
        logic [LEN_W-1:0] len_m1;
        logic             cpol;
        logic             cpha;
        logic             lsb_first;
        logic [CNT_W-1:0] setup_cyc;
        logic [CNT_W-1:0] hold_cyc;
        logic [CNT_W-1:0] half_cyc;
    } frame_cfg_t;

    // odd prescaler (1,3,5,7) times 2^(scaler + extra)
    function automatic logic [CNT_W-1:0] scaled_cycles(
        input logic [1:0] pre_code,
        input logic [3:0] sc_code,
        input logic       extra
    );
        logic [CNT_W-1:0] base;
        logic [4:0]       amt;
        base = CNT_W'({pre_code, 1'b1});
        amt  = {1'b0, sc_code} + {4'b0000, extra};
        return base << amt;
    endfunction

    // position of frame bit k inside the data word
    function automatic logic [LEN_W-1:0] bit_pos(
        input logic [LEN_W-1:0] k,
        input logic [LEN_W-1:0] len_m1,
        input logic             lsb_first
    );
        return lsb_first ? k : (len_m1 - k);
    endfunction

endpackage

// File: rtl/spi_fm_decode.sv
module spi_fm_decode
    import spi_fm_pkg::*;
(
    input  logic [31:0] cfg_word,
    output frame_cfg_t  cfg
);
    logic [LEN_W-1:0] raw_len;

    always_comb begin
        raw_len       = cfg_word[F_LEN_LO +: LEN_W];
        cfg.len_m1    = (raw_len < MIN_LEN_M1) ? MIN_LEN_M1 : raw_len;
        cfg.cpol      = cfg_word[F_CPOL];
        cfg.cpha      = cfg_word[F_CPHA];
        cfg.lsb_first = cfg_word[F_LSB];
        cfg.setup_cyc = scaled_cycles(cfg_word[F_SPRE_LO +: 2],
                                      cfg_word[F_SSC_LO +: 4], 1'b1);
        cfg.hold_cyc  = scaled_cycles(cfg_word[F_HPRE_LO +: 2],
                                      cfg_word[F_HSC_LO +: 4], 1'b1);
        cfg.half_cyc  = scaled_cycles(cfg_word[F_BPRE_LO +: 2],
                                      cfg_word[F_BSC_LO +: 4], 1'b0);
    end

endmodule

// File: rtl/spi_fm_timer.sv
module spi_fm_timer #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter
    import spi_fm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              lsb_first,
    input  logic              cpha,
    input  logic              edge_stb,
    input  logic              leading,
    input  logic              first_edge,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [LEN_W-1:0]  tx_idx;
    logic [LEN_W-1:0]  rx_idx;
    logic              advance;
    logic              capture;

    always_comb begin
        if (cpha) begin
            advance = edge_stb && leading && !first_edge;
            capture = edge_stb && !leading;
        end else begin
            advance = edge_stb && !leading;
            capture = edge_stb && leading;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            rx_q   <= '0;
            tx_idx <= '0;
            rx_idx <= '0;
        end else if (load) begin
            tx_q   <= tx_word;
            rx_q   <= '0;
            tx_idx <= '0;
            rx_idx <= '0;
        end else begin
            if (advance && (tx_idx != len_m1)) begin
                tx_idx <= tx_idx + 1'b1;
            end
            if (capture) begin
                rx_q[bit_pos(rx_idx, len_m1, lsb_first)] <= miso;
                if (rx_idx != len_m1) begin
                    rx_idx <= rx_idx + 1'b1;
                end
            end
        end
    end

    assign mosi    = tx_q[bit_pos(tx_idx, len_m1, lsb_first)];
    assign rx_word = rx_q;

    // R6
    idx_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_idx <= len_m1) && (rx_idx <= len_m1));

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import spi_fm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] cfg_word,
    input  logic        start,
    input  logic [15:0] tx_data,
    output logic        busy,
    output logic        done,
    output logic [15:0] rx_data,
    output logic        sck,
    output logic        mosi,
    output logic        cs_n,
    input  logic        miso
);
    fm_state_t         state_q;
    frame_cfg_t        cfg_live;
    frame_cfg_t        cfg_q;
    logic              sck_q;
    logic              done_q;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] last_edge;
    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_zero;
    logic              accept;
    logic              edge_stb;

    spi_fm_decode u_decode (
        .cfg_word (cfg_word),
        .cfg      (cfg_live)
    );

    spi_fm_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    assign accept    = (state_q == ST_IDLE) && start;
    assign edge_stb  = (state_q == ST_SHIFT) && t_zero;
    assign last_edge = {1'b0, cfg_q.len_m1, 1'b1};

    spi_fm_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .tx_word    (tx_data),
        .len_m1     (cfg_q.len_m1),
        .lsb_first  (cfg_q.lsb_first),
        .cpha       (cfg_q.cpha),
        .edge_stb   (edge_stb),
        .leading    (~edge_cnt[0]),
        .first_edge (edge_cnt == '0),
        .miso       (miso),
        .mosi       (mosi),
        .rx_word    (rx_data)
    );

    always_comb begin
        t_load = 1'b0;
        t_val  = cfg_q.half_cyc - 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    t_load = 1'b1;
                    t_val  = cfg_live.setup_cyc - 1'b1;
                end
            end
            ST_SETUP: begin
                t_load = t_zero;
            end
            ST_SHIFT: begin
                t_load = t_zero;
                if (edge_cnt == last_edge) begin
                    t_val = cfg_q.hold_cyc - 1'b1;
                end
            end
            default: begin
                t_load = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cfg_q    <= '0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
            edge_cnt <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    sck_q <= cfg_live.cpol;
                    if (start) begin
                        cfg_q   <= cfg_live;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (t_zero) begin
                        state_q  <= ST_SHIFT;
                        edge_cnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (t_zero) begin
                        sck_q    <= ~sck_q;
                        edge_cnt <= edge_cnt + 1'b1;
                        if (edge_cnt == last_edge) begin
                            state_q <= ST_HOLD;
                        end
                    end
                end
                default: begin
                    if (t_zero) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign cs_n = (state_q == ST_IDLE);
    assign sck  = sck_q;
    assign done = done_q;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_at_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && $past(!cs_n)));

    // R3
    sck_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETUP || state_q == ST_HOLD) |-> (sck_q == cfg_q.cpol));

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(cfg_q));

    // R3
    edge_total_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |-> (edge_cnt == last_edge + 1'b1));

endmodule

// File: tb/spi_frame_master_tb.sv
`timescale 1ns/1ps
module spi_frame_master_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cfg_word;
    logic        start;
    logic [15:0] tx_data;
    logic        busy, done, sck, mosi, cs_n, miso;
    logic [15:0] rx_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_frame_master u_dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_word (cfg_word),
        .start    (start),
        .tx_data  (tx_data),
        .busy     (busy),
        .done     (done),
        .rx_data  (rx_data),
        .sck      (sck),
        .mosi     (mosi),
        .cs_n     (cs_n),
        .miso     (miso)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input int len_code, input int cpol, input int cpha,
                                           input int lsb, input int spre, input int hpre,
                                           input int bpre, input int ssc, input int hsc,
                                           input int bsc);
        logic [31:0] w;
        w = '0;
        w[30:27] = len_code[3:0];
        w[26] = cpol[0];
        w[25] = cpha[0];
        w[24] = lsb[0];
        w[23:22] = spre[1:0];
        w[21:20] = hpre[1:0];
        w[17:16] = bpre[1:0];
        w[15:12] = ssc[3:0];
        w[11:8] = hsc[3:0];
        w[3:0] = bsc[3:0];
        return w;
    endfunction

    function automatic int bit_index(input int e, input int cpha, input int n);
        int k;
        if (cpha == 0) k = e / 2;
        else k = (e <= 1) ? 0 : (e - 1) / 2;
        if (k > n - 1) k = n - 1;
        return k;
    endfunction

    function automatic logic frame_bit(input logic [15:0] w, input int k, input int n, input int lsb);
        return lsb ? w[k] : w[n - 1 - k];
    endfunction

    task automatic run_frame(input logic [31:0] cfg, input logic [15:0] tx,
                             input logic [15:0] slv, input int poke_t);
        int n, cpol, cpha, lsb, s, hd, h, tt, e, k;
        logic [15:0] mask;
        n    = int'(cfg[30:27]) + 1;
        if (n < 4) n = 4;
        cpol = int'(cfg[26]);
        cpha = int'(cfg[25]);
        lsb  = int'(cfg[24]);
        s    = (2 * int'(cfg[23:22]) + 1) * (2 << int'(cfg[15:12]));
        hd   = (2 * int'(cfg[21:20]) + 1) * (2 << int'(cfg[11:8]));
        h    = (2 * int'(cfg[17:16]) + 1) * (1 << int'(cfg[3:0]));
        tt   = s + 2 * n * h + hd;
        mask = 16'((32'd1 << n) - 1);

        @(negedge clk);
        cfg_word = cfg;
        tx_data  = tx;
        start    = 1'b1;
        miso     = frame_bit(slv, 0, n, lsb);
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= tt + 1; t++) begin
            e = (t < s) ? 0 : (t - s) / h;
            if (e > 2 * n) e = 2 * n;
            k = bit_index(e, cpha, n);
            if (t < tt) begin
                check(cs_n == 1'b0, (t < s) ? "R2 cs_n low in setup" :
                      ((t < s + 2 * n * h) ? "R2 cs_n low in shift" : "R7 cs_n low in hold"),
                      int'(cs_n), 0);
                check(busy == 1'b1, "R2 busy", int'(busy), 1);
                check(done == 1'b0, "R8 done early", int'(done), 0);
                check(sck == logic'(cpol ^ (e & 1)), "R3 sck level", int'(sck), cpol ^ (e & 1));
                if (t < s + 2 * n * h) begin
                    check(mosi == frame_bit(tx, k, n, lsb),
                          lsb ? "R5 mosi lsb-first R4" : "R5 mosi msb-first R4",
                          int'(mosi), int'(frame_bit(tx, k, n, lsb)));
                end
            end else if (t == tt) begin
                check(cs_n == 1'b1, "R7 cs_n rise", int'(cs_n), 1);
                check(done == 1'b1, "R8 done pulse", int'(done), 1);
                check(rx_data == (slv & mask), "R8 rx_data R6", int'(rx_data), int'(slv & mask));
            end else begin
                check(done == 1'b0, "R8 done one cycle", int'(done), 0);
                check(cs_n == 1'b1 && busy == 1'b0, "R9 no second frame", int'({cs_n, busy}), 2);
            end
            miso = frame_bit(slv, k, n, lsb);
            if (t == poke_t) begin
                start    = 1'b1;
                tx_data  = ~tx;
                cfg_word = cfg ^ 32'h0700_0000;
            end else if (t == poke_t + 1) begin
                start    = 1'b0;
                tx_data  = tx;
                cfg_word = cfg;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_word = '0; start = 1'b0; tx_data = '0; miso = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1 cs_n idle", int'(cs_n), 1);
        check(busy == 1'b0, "R1 busy idle", int'(busy), 0);
        check(done == 1'b0, "R1 done idle", int'(done), 0);
        check(sck == 1'b0, "R1 sck idle", int'(sck), 0);

        // 8 bits, mode 0, msb first, fastest clock, shortest delays
        run_frame(mk_cfg(7, 0, 0, 0, 0, 0, 0, 0, 0, 0), 16'h00A5, 16'h003C, -5);
        // 16 bits, mode 3, lsb first, H=6, S=20, hold=14
        run_frame(mk_cfg(15, 1, 1, 1, 2, 3, 1, 1, 0, 1), 16'hC3E1, 16'h5A96, -5);
        // code 1 -> 4-bit frame (R6), mode 1, start and cfg poked mid-frame (R9)
        run_frame(mk_cfg(1, 0, 1, 0, 1, 0, 0, 0, 1, 1), 16'hFFF9, 16'hFFF6, 10);
        // 12 bits, mode 2, lsb first, H=5, S=24, hold=16, poke during hold
        run_frame(mk_cfg(11, 1, 0, 1, 1, 0, 2, 2, 3, 0), 16'h0B72, 16'h0ACE, 150);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule